// File: doc/BRIEF.md
# Calendar Time-of-Day Counter with Alarm

This block keeps the wall-clock time and the calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle `sec_tick` pulse from an external divider moves the time forward by one second. The time is held as a binary counter inside the block. Seven register bytes face the host, and each byte is coded either as packed BCD or as plain binary. The hours byte is coded in 12-hour or 24-hour form.

The host writes any field through a simple write port. After each accepted second, the block compares three alarm bytes against the new seconds, minutes and hours. When all three agree it raises `alarm_hit` for one cycle, and it raises `update_done` for one cycle on every accepted second. A set-mode input freezes the host-facing bytes so that software can load a new time without a partial update. When set mode is left, the counter reloads from the bytes the host wrote.

Top module: `caltime_core`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01 and year 0x00, and `update_done` and `alarm_hit` are low.
- R2: Seconds wrap from 59 to 0 and minutes wrap from 59 to 0, each carrying one into the next field. Hours wrap from 23 to 0 and carry into both the day of week and the day of month.
- R3: Day of week counts 1 to 7 and wraps from 7 to 1. Month counts 1 to 12 and wraps from 12 to 1, incrementing the year. The year wraps from 99 to 0.
- R4: The day of month wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when BASE_YEAR plus the year register is divisible by 4 and either not divisible by 100 or divisible by 400; otherwise it has 28. All other months have 31 days.
- R5: With `fmt_binary` low, each register byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With `fmt_binary` high, each byte is the plain binary value.
- R6: With `fmt_24h` low, the hours byte holds the hour modulo 12 and bit 7 is set for hours 12 to 23. On a write in this mode, bit 7 adds 12 to the decoded hour. With `fmt_24h` high, the hours byte holds 0 to 23.
- R7: After an accepted second, `alarm_hit` pulses in the same cycle as `update_done` when each of the alarm bytes (`alm_sec`, `alm_min`, `alm_hour`) either has bits 7:6 equal to 11 or equals the new register-format value of its field.
- R8: A `sec_tick` accepted at a clock edge advances the counter at that edge. `update_done` is high for exactly the following cycle, and in that cycle the registers show the new time unless set mode is active.
- R9: While `osc_ctl` differs from 3'b010, a `sec_tick` is ignored: the counter does not move and no `update_done` or `alarm_hit` pulse occurs.
- R10: While `set_mode` is high, ticks still advance the counter but leave the register bytes unchanged. Writes change the register byte but not the counter. When `set_mode` falls, the counter reloads from the decoded register bytes.
- R11: With `wr_en` high, the byte selected by `wr_sel` takes `wr_data` one cycle later. The select codes are 0 for seconds, 1 for minutes, 2 for hours, 3 for day of week, 4 for day of month, 5 for month and 6 for year. Outside set mode, the counter reloads from all seven decoded bytes, including the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse requesting a one-second advance |
| osc_ctl | input | 3 | Oscillator control field; ticks count only at 3'b010 |
| fmt_binary | input | 1 | 1 = binary register bytes, 0 = packed BCD |
| fmt_24h | input | 1 | 1 = 24-hour hours byte, 0 = 12-hour with PM in bit 7 |
| set_mode | input | 1 | Freezes register bytes; its falling edge reloads the counter |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for a write (0 seconds to 6 year) |
| wr_data | input | 8 | Register-format byte to write |
| alm_sec | input | 8 | Seconds alarm byte; bits 7:6 = 11 matches any value |
| alm_min | input | 8 | Minutes alarm byte; bits 7:6 = 11 matches any value |
| alm_hour | input | 8 | Hours alarm byte; bits 7:6 = 11 matches any value |
| t_sec | output | 8 | Seconds register byte |
| t_min | output | 8 | Minutes register byte |
| t_hour | output | 8 | Hours register byte |
| t_dow | output | 8 | Day-of-week register byte |
| t_dom | output | 8 | Day-of-month register byte |
| t_mon | output | 8 | Month register byte |
| t_year | output | 8 | Year register byte |
| update_done | output | 1 | One-cycle pulse after each accepted second |
| alarm_hit | output | 1 | One-cycle pulse when the alarm bytes match the new time |

## Verification
The range assertions on the internal counter hold only if every byte the host writes is a legal value in the format in force when it is decoded. They also require that format changes never cause stale bytes to be decoded under the new coding. The stimulus meets both conditions. It changes `fmt_binary` or `fmt_24h` only before a full reload, and it performs that reload inside set mode: all seven fields are written with the active coding, and then set mode is left. The stimulus also never lets a tick coincide with a write or with the falling edge of `set_mode`.

// File: rtl/caltime_pkg.sv
`timescale 1ns/1ps
package caltime_pkg;

   localparam int FIELD_N = 7;
   localparam int REG_W   = 8;

   typedef enum logic [2:0] {
      F_SEC  = 3'd0,
      F_MIN  = 3'd1,
      F_HOUR = 3'd2,
      F_DOW  = 3'd3,
      F_DOM  = 3'd4,
      F_MON  = 3'd5,
      F_YEAR = 3'd6
   } field_e;

   typedef struct packed {
      logic [6:0] yr;
      logic [3:0] mon;
      logic [4:0] dom;
      logic [2:0] dow;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } tod_t;

   typedef logic [FIELD_N-1:0][REG_W-1:0] regset_t;

   // binary 0..99 -> register byte
   function automatic logic [REG_W-1:0] to_reg(logic [6:0] v, logic bin);
      logic [3:0] tens;
      logic [3:0] units;
      tens  = 4'(v / 7'd10);
      units = 4'(v % 7'd10);
      if (bin) return {1'b0, v};
      return {tens, units};
   endfunction

   // register byte -> binary
   function automatic logic [6:0] from_reg(logic [REG_W-1:0] b, logic bin);
      if (bin) return b[6:0];
      return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
   endfunction

   function automatic logic [REG_W-1:0] hour_to_reg(logic [6:0] h, logic bin, logic h24);
      logic       pm;
      logic [6:0] h12;
      pm  = (h >= 7'd12);
      h12 = pm ? h - 7'd12 : h;
      if (h24) return to_reg(h, bin);
      return to_reg(h12, bin) | {pm, 7'b0};
   endfunction

   function automatic logic [6:0] hour_from_reg(logic [REG_W-1:0] b, logic bin, logic h24);
      if (h24) return from_reg(b, bin);
      return from_reg({1'b0, b[6:0]}, bin) + (b[7] ? 7'd12 : 7'd0);
   endfunction

endpackage

// File: rtl/caltime_step.sv
`timescale 1ns/1ps
module caltime_step
   import caltime_pkg::*;
#(
   parameter int BASE_YEAR = 1980
)(
   input  tod_t cur,
   output tod_t nxt
);

   localparam logic [5:0] SEC_LAST  = 6'd59;
   localparam logic [5:0] MIN_LAST  = 6'd59;
   localparam logic [4:0] HOUR_LAST = 5'd23;
   localparam logic [2:0] DOW_LAST  = 3'd7;
   localparam logic [3:0] MON_LAST  = 4'd12;
   localparam logic [6:0] YR_LAST   = 7'd99;

   function automatic logic [4:0] month_len(logic [3:0] m, logic leap_yr);
      case (m)
         4'd2:                      return leap_yr ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
         default:                   return 5'd31;
      endcase
   endfunction

   int         full_year;
   logic       leap;
   logic [4:0] mlen;

   always_comb begin
      full_year = BASE_YEAR + int'(cur.yr);
      leap      = ((full_year % 4) == 0) &&
                  (((full_year % 100) != 0) || ((full_year % 400) == 0));
      mlen      = month_len(cur.mon, leap);
      nxt       = cur;
      if (cur.sec != SEC_LAST) begin
         nxt.sec = cur.sec + 6'd1;
      end else begin
         nxt.sec = '0;
         if (cur.min != MIN_LAST) begin
            nxt.min = cur.min + 6'd1;
         end else begin
            nxt.min = '0;
            if (cur.hour != HOUR_LAST) begin
               nxt.hour = cur.hour + 5'd1;
            end else begin
               nxt.hour = '0;
               nxt.dow  = (cur.dow >= DOW_LAST) ? 3'd1 : cur.dow + 3'd1;
               if (cur.dom < mlen) begin
                  nxt.dom = cur.dom + 5'd1;
               end else begin
                  nxt.dom = 5'd1;
                  if (cur.mon < MON_LAST) begin
                     nxt.mon = cur.mon + 4'd1;
                  end else begin
                     nxt.mon = 4'd1;
                     nxt.yr  = (cur.yr >= YR_LAST) ? 7'd0 : cur.yr + 7'd1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/caltime_codec.sv
`timescale 1ns/1ps
module caltime_codec
   import caltime_pkg::*;
(
   input  logic    bin_mode,
   input  logic    h24_mode,
   input  tod_t    enc_in,
   output regset_t enc_out,
   input  regset_t dec_in,
   output tod_t    dec_out
);

   logic [FIELD_N-1:0][6:0] bin_e;
   logic [FIELD_N-1:0][6:0] bin_d;

   assign bin_e = {enc_in.yr,
                   3'b0, enc_in.mon,
                   2'b0, enc_in.dom,
                   4'b0, enc_in.dow,
                   2'b0, enc_in.hour,
                   1'b0, enc_in.min,
                   1'b0, enc_in.sec};

   for (genvar i = 0; i < FIELD_N; i++) begin : g_field
      if (i == int'(F_HOUR)) begin : g_hour
         assign enc_out[i] = hour_to_reg(bin_e[i], bin_mode, h24_mode);
         assign bin_d[i]   = hour_from_reg(dec_in[i], bin_mode, h24_mode);
      end else begin : g_plain
         assign enc_out[i] = to_reg(bin_e[i], bin_mode);
         assign bin_d[i]   = from_reg(dec_in[i], bin_mode);
      end
   end

   assign dec_out.sec  = bin_d[F_SEC][5:0];
   assign dec_out.min  = bin_d[F_MIN][5:0];
   assign dec_out.hour = bin_d[F_HOUR][4:0];
   assign dec_out.dow  = bin_d[F_DOW][2:0];
   assign dec_out.dom  = bin_d[F_DOM][4:0];
   assign dec_out.mon  = bin_d[F_MON][3:0];
   assign dec_out.yr   = bin_d[F_YEAR];

endmodule

// File: rtl/caltime_alarm.sv
`timescale 1ns/1ps
module caltime_alarm #(
   parameter int         N     = 3,
   parameter int         W     = 8,
   parameter logic [1:0] WILD  = 2'b11
)(
   input  logic [N-1:0][W-1:0] alm,
   input  logic [N-1:0][W-1:0] cur,
   output logic                hit
);

   if (N < 1 || W < 2) begin : g_bad_cfg
      $error("caltime_alarm: N must be >= 1 and W >= 2");
   end

   logic [N-1:0] fld_ok;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign fld_ok[i] = (alm[i][W-1:W-2] == WILD) || (alm[i] == cur[i]);
   end

   assign hit = &fld_ok;

endmodule

// File: rtl/caltime_core.sv
`timescale 1ns/1ps
module caltime_core
   import caltime_pkg::*;
#(
   parameter int         BASE_YEAR = 1980,
   parameter logic [2:0] OSC_RUN   = 3'b010
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic [2:0] osc_ctl,
   input  logic       fmt_binary,
   input  logic       fmt_24h,
   input  logic       set_mode,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   input  logic [7:0] alm_sec,
   input  logic [7:0] alm_min,
   input  logic [7:0] alm_hour,
   output logic [7:0] t_sec,
   output logic [7:0] t_min,
   output logic [7:0] t_hour,
   output logic [7:0] t_dow,
   output logic [7:0] t_dom,
   output logic [7:0] t_mon,
   output logic [7:0] t_year,
   output logic       update_done,
   output logic       alarm_hit
);

   localparam int ALM_N = 3;

   if (BASE_YEAR < 1 || BASE_YEAR > 9999) begin : g_bad_year
      $error("caltime_core: BASE_YEAR out of range");
   end
   if (REG_W != 8) begin : g_bad_width
      $error("caltime_core: register width must be 8");
   end

   localparam regset_t RST_REGS = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
   localparam tod_t    RST_TOD  = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                                    hour: 5'd0, min: 6'd0, sec: 6'd0};

   tod_t    cnt_q;
   tod_t    cnt_nxt;
   tod_t    cnt_dec;
   regset_t disp_q;
   regset_t disp_wr;
   regset_t disp_enc;
   logic    set_q;
   logic    leave_set;
   logic    osc_ok;
   logic    advance;
   logic    match_c;
   logic    upd_q;
   logic    alm_q;

   assign osc_ok    = (osc_ctl == OSC_RUN);
   assign leave_set = set_q && !set_mode;
   assign advance   = sec_tick && osc_ok && !wr_en && !leave_set;

   always_comb begin
      disp_wr = disp_q;
      if (wr_en && (int'(wr_sel) < FIELD_N)) disp_wr[wr_sel] = wr_data;
   end

   caltime_step #(.BASE_YEAR(BASE_YEAR)) u_step (
      .cur (cnt_q),
      .nxt (cnt_nxt)
   );

   caltime_codec u_codec (
      .bin_mode (fmt_binary),
      .h24_mode (fmt_24h),
      .enc_in   (cnt_nxt),
      .enc_out  (disp_enc),
      .dec_in   (disp_wr),
      .dec_out  (cnt_dec)
   );

   caltime_alarm #(.N(ALM_N), .W(REG_W), .WILD(2'b11)) u_alarm (
      .alm ({alm_hour, alm_min, alm_sec}),
      .cur (disp_enc[ALM_N-1:0]),
      .hit (match_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= RST_TOD;
         disp_q <= RST_REGS;
         set_q  <= 1'b0;
         upd_q  <= 1'b0;
         alm_q  <= 1'b0;
      end else begin
         set_q <= set_mode;
         upd_q <= 1'b0;
         alm_q <= 1'b0;
         if (wr_en) begin
            disp_q <= disp_wr;
            if (!set_mode) cnt_q <= cnt_dec;
         end else if (leave_set) begin
            cnt_q <= cnt_dec;
         end else if (advance) begin
            cnt_q <= cnt_nxt;
            upd_q <= 1'b1;
            alm_q <= match_c;
            if (!set_mode) disp_q <= disp_enc;
         end
      end
   end

   assign t_sec       = disp_q[F_SEC];
   assign t_min       = disp_q[F_MIN];
   assign t_hour      = disp_q[F_HOUR];
   assign t_dow       = disp_q[F_DOW];
   assign t_dom       = disp_q[F_DOM];
   assign t_mon       = disp_q[F_MON];
   assign t_year      = disp_q[F_YEAR];
   assign update_done = upd_q;
   assign alarm_hit   = alm_q;

   // R8
   upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_done |-> $past(sec_tick && osc_ok && !wr_en));

   // R7
   alarm_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |-> update_done);

   // R9
   osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_ok && !wr_en && !leave_set) |=> $stable(cnt_q));

   // R10
   set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mode && !wr_en) |=> $stable(disp_q));

   // R11
   wr_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == F_SEC) |=> (t_sec == $past(wr_data)));

   // R2
   tod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q.sec < 6'd60) && (cnt_q.min < 6'd60) && (cnt_q.hour < 5'd24));

   // R3
   cal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q.dow >= 3'd1) && (cnt_q.mon >= 4'd1) && (cnt_q.mon <= 4'd12) &&
      (cnt_q.yr <= 7'd99));

   // R4
   dom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q.dom >= 5'd1) && (cnt_q.dom <= 5'd31));

endmodule

// File: tb/test_caltime_core.sv
`timescale 1ns/1ps
module test_caltime_core;

   typedef logic [6:0][7:0] regs_t;
   typedef struct packed {
      regs_t regs;
      logic  alm;
   } exp_t;

   logic       clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n      = 1'b0;
   logic       sec_tick   = 1'b0;
   logic [2:0] osc_ctl    = 3'b010;
   logic       fmt_binary = 1'b0;
   logic       fmt_24h    = 1'b1;
   logic       set_mode   = 1'b0;
   logic       wr_en      = 1'b0;
   logic [2:0] wr_sel     = 3'd0;
   logic [7:0] wr_data    = 8'h00;
   logic [7:0] alm_sec    = 8'h77;
   logic [7:0] alm_min    = 8'h77;
   logic [7:0] alm_hour   = 8'h77;
   logic [7:0] t_sec, t_min, t_hour, t_dow, t_dom, t_mon, t_year;
   logic       update_done, alarm_hit;

   caltime_core i_caltime_core (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_ctl(osc_ctl),
      .fmt_binary(fmt_binary), .fmt_24h(fmt_24h), .set_mode(set_mode),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
      .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_dow(t_dow),
      .t_dom(t_dom), .t_mon(t_mon), .t_year(t_year),
      .update_done(update_done), .alarm_hit(alarm_hit)
   );

   regs_t dut_regs;
   assign dut_regs = {t_year, t_mon, t_dom, t_dow, t_hour, t_min, t_sec};

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_tag = "R1";
   int    m_s, m_m, m_h, m_dw, m_dm, m_mo, m_yr;
   regs_t exp_disp;
   exp_t  sb_q[$];
   exp_t  mon_e;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] b_enc(int v);
      return fmt_binary ? 8'(v) : 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic logic [7:0] h_enc(int h);
      if (fmt_24h) return b_enc(h);
      return b_enc(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic int b_dec(logic [7:0] b);
      return fmt_binary ? int'(b) : int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic regs_t enc_model();
      regs_t r;
      r[0] = b_enc(m_s);  r[1] = b_enc(m_m);  r[2] = h_enc(m_h);
      r[3] = b_enc(m_dw); r[4] = b_enc(m_dm); r[5] = b_enc(m_mo);
      r[6] = b_enc(m_yr);
      return r;
   endfunction

   function automatic bit m_alarm();
      regs_t r;
      r = enc_model();
      return ((alm_sec[7:6]  == 2'b11) || (alm_sec  == r[0])) &&
             ((alm_min[7:6]  == 2'b11) || (alm_min  == r[1])) &&
             ((alm_hour[7:6] == 2'b11) || (alm_hour == r[2]));
   endfunction

   function automatic int m_days();
      int full;
      full = 1980 + m_yr;
      if (m_mo == 2)
         return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
      if (m_mo == 4 || m_mo == 6 || m_mo == 9 || m_mo == 11) return 30;
      return 31;
   endfunction

   function automatic void m_step();
      m_s++;
      if (m_s == 60) begin
         m_s = 0; m_m++;
         if (m_m == 60) begin
            m_m = 0; m_h++;
            if (m_h == 24) begin
               m_h = 0;
               m_dw = (m_dw == 7) ? 1 : m_dw + 1;
               if (m_dm >= m_days()) begin
                  m_dm = 1;
                  if (m_mo == 12) begin
                     m_mo = 1;
                     m_yr = (m_yr == 99) ? 0 : m_yr + 1;
                  end else m_mo++;
               end else m_dm++;
            end
         end
      end
   endfunction

   function automatic void m_load();
      m_s  = b_dec(exp_disp[0]);
      m_m  = b_dec(exp_disp[1]);
      if (fmt_24h) m_h = b_dec(exp_disp[2]);
      else m_h = b_dec({1'b0, exp_disp[2][6:0]}) + (exp_disp[2][7] ? 12 : 0);
      m_dw = b_dec(exp_disp[3]);
      m_dm = b_dec(exp_disp[4]);
      m_mo = b_dec(exp_disp[5]);
      m_yr = b_dec(exp_disp[6]);
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && alarm_hit && !update_done) begin
         n_tests++; n_fail++;
         $display("FAIL %s R7 alarm without update act=1 exp=0", cur_tag);
      end
      if (rst_n && update_done) begin
         if (sb_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL %s R9 unexpected update pulse act=1 exp=0", cur_tag);
         end else begin
            mon_e = sb_q.pop_front();
            chk({cur_tag, " R8 registers after update"}, 64'(dut_regs), 64'(mon_e.regs));
            chk({cur_tag, " R7 alarm pulse"}, 64'(alarm_hit), 64'(mon_e.alm));
         end
      end
   end

   task automatic do_tick();
      if (osc_ctl == 3'b010) begin
         m_step();
         if (!set_mode) exp_disp = enc_model();
         sb_q.push_back('{regs: exp_disp, alm: m_alarm()});
      end
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      @(negedge clk);
      chk({cur_tag, " R8 update consumed"}, 64'(sb_q.size()), 64'd0);
   endtask

   task automatic wr(int sel, logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
      exp_disp[sel] = b;
      if (!set_mode) m_load();
      chk({cur_tag, " R11 write visible"}, 64'(dut_regs), 64'(exp_disp));
   endtask

   task automatic enter_set();
      @(negedge clk) set_mode = 1'b1;
   endtask

   task automatic leave_set();
      @(negedge clk) set_mode = 1'b0;
      m_load();
      @(negedge clk);
   endtask

   task automatic wr_all(int h, int mi, int s, int dw, int dm, int mo, int yr);
      enter_set();
      wr(2, h_enc(h)); wr(1, b_enc(mi)); wr(0, b_enc(s));
      wr(3, b_enc(dw)); wr(4, b_enc(dm)); wr(5, b_enc(mo)); wr(6, b_enc(yr));
      leave_set();
   endtask

   initial begin
      #(20 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      m_s = 0; m_m = 0; m_h = 0; m_dw = 1; m_dm = 1; m_mo = 1; m_yr = 0;
      exp_disp = enc_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      cur_tag = "R1";
      chk("R1 reset registers", 64'(dut_regs), 64'({8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00}));
      chk("R1 reset update_done", 64'(update_done), 64'd0);
      chk("R1 reset alarm_hit", 64'(alarm_hit), 64'd0);

      cur_tag = "R8 first seconds";
      repeat (3) do_tick();
      chk("R8 seconds after three ticks", 64'(t_sec), 64'h03);

      cur_tag = "R2 R3 R4 leap day";
      wr_all(23, 59, 58, 7, 28, 2, 24);
      repeat (3) do_tick();
      chk("R4 leap year day 29", 64'(t_dom), 64'h29);
      chk("R3 day of week wrap", 64'(t_dow), 64'h01);

      cur_tag = "R4 400-year leap";
      wr_all(23, 59, 59, 2, 28, 2, 20);
      do_tick();
      chk("R4 year 2000 day 29", 64'(t_dom), 64'h29);

      cur_tag = "R4 common year";
      wr_all(23, 59, 59, 3, 28, 2, 23);
      do_tick();
      chk("R4 common year to March", 64'({t_mon, t_dom}), 64'h0301);

      cur_tag = "R4 thirty-day month";
      wr_all(23, 59, 59, 4, 30, 4, 10);
      do_tick();
      chk("R4 April 30 to May 1", 64'({t_mon, t_dom}), 64'h0501);

      cur_tag = "R3 year wrap";
      wr_all(23, 59, 59, 5, 31, 12, 99);
      do_tick();
      chk("R3 year 99 to 0", 64'({t_year, t_mon, t_dom}), 64'h000101);

      cur_tag = "R5 binary mode";
      fmt_binary = 1'b1;
      wr_all(23, 59, 59, 5, 30, 6, 45);
      repeat (2) do_tick();
      chk("R5 binary year byte", 64'(t_year), 64'h2D);
      chk("R5 binary month byte", 64'(t_mon), 64'h07);

      cur_tag = "R6 twelve-hour noon";
      fmt_binary = 1'b0;
      fmt_24h    = 1'b0;
      wr_all(11, 59, 59, 1, 5, 3, 5);
      do_tick();
      chk("R6 noon hour byte", 64'(t_hour), 64'h80);

      cur_tag = "R6 twelve-hour midnight";
      wr_all(23, 59, 59, 2, 9, 3, 5);
      do_tick();
      chk("R6 midnight hour byte", 64'(t_hour), 64'h00);
      chk("R2 hour carry into day", 64'(t_dom), 64'h10);

      cur_tag = "R6 twelve-hour afternoon";
      wr_all(13, 4, 59, 2, 9, 3, 5);
      do_tick();
      chk("R6 1 PM hour byte", 64'({t_hour, t_min}), 64'h8105);

      cur_tag = "R7 exact alarm";
      fmt_24h = 1'b1;
      wr_all(10, 20, 30, 3, 15, 6, 10);
      alm_hour = 8'h10; alm_min = 8'h20; alm_sec = 8'h32;
      repeat (3) do_tick();

      cur_tag = "R7 wildcard all";
      alm_hour = 8'hC0; alm_min = 8'hC0; alm_sec = 8'hC0;
      do_tick();

      cur_tag = "R7 partial wildcard";
      alm_hour = 8'hFF; alm_min = 8'h21; alm_sec = 8'hC0;
      do_tick();
      cur_tag = "R11 single write";
      wr(0, 8'h59);
      chk("R11 single write seconds", 64'(t_sec), 64'h59);
      cur_tag = "R7 R11 minute match";
      do_tick();
      chk("R2 minute carry", 64'({t_min, t_sec}), 64'h2100);
      alm_hour = 8'h77; alm_min = 8'h77; alm_sec = 8'h77;

      cur_tag = "R9 oscillator stopped";
      osc_ctl = 3'b000;
      do_tick();
      osc_ctl = 3'b011;
      do_tick();
      chk("R9 registers held", 64'(dut_regs), 64'(exp_disp));
      osc_ctl = 3'b010;
      do_tick();
      chk("R9 only one second after restart", 64'(t_sec), 64'h01);

      cur_tag = "R10 set mode";
      enter_set();
      repeat (2) do_tick();
      chk("R10 registers frozen", 64'(dut_regs), 64'(exp_disp));
      wr(0, 8'h40);
      alm_hour = 8'hC0; alm_min = 8'hC0; alm_sec = b_enc((m_s + 1) % 60);
      do_tick();
      chk("R10 written byte kept", 64'(t_sec), 64'h40);
      alm_hour = 8'h77; alm_min = 8'h77; alm_sec = 8'h77;
      leave_set();
      do_tick();
      chk("R10 reload on leaving", 64'(t_sec), 64'h41);

      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule